// File: doc/BRIEF.md
# Two-Phase Clock and Strobe Generator

This block turns one fast global clock into a slow, two-phase clocking scheme. One slow cycle takes sixteen fast-clock steps. A 4-bit Gray-code sequencer counts the steps, and the phase enables, the strobe and the update pulse are all decoded from it. Each fast-clock edge changes exactly one sequencer bit, so a decode of the sequencer can take only one path per step.

A next-state bus goes through two registered ranks, as a master-slave flip-flop would. The first rank samples the bus once per slow cycle, at a fixed step in the first half. The second rank copies the first rank at the step-7 to step-8 boundary. The two ranks never load on the same step.

The strobe is low only around the second-rank update. Downstream logic ANDs the strobe with any decode of the stable state bits, so that a decode acts only while those bits are settled. The next-state bus is sampled once per slow cycle rather than exchanged through a handshake. It is not a stream, so there is no valid/ready pair and no back-pressure. The source only has to hold the bus steady across the capture step.

Top module: `twophase_strobe_gen`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the block goes to step 0. After that edge, `phase_gray_o` is 0000, `strobe_o` is 1, `phi1_o`, `phi2_o` and `update_o` are 0, and both ranks are cleared, so `state_o` is 0.
- R2: Each clock edge out of reset advances the step index s by one, modulo 16. `phase_gray_o` shows s ^ (s >> 1), so exactly one bit changes per edge and the pattern repeats every 16 clocks.
- R3: `phi1_o` is high exactly during steps 1 to 6. `phi2_o` is high exactly during steps 9 to 14. The two are never high together.
- R4: `strobe_o` is low exactly during steps 7 and 8 and high during the other 14 steps. It is a register output.
- R5: The first rank loads `next_state_i` at the clock edge that ends step CAPT_STEP. CAPT_STEP is a parameter in the range 0 to 6. The value on `next_state_i` at every other edge has no effect on `state_o`.
- R6: `state_o` changes only at the edge that enters step 8. It then takes the value held by the first rank.
- R7: `update_o` is high for exactly one clock per slow cycle, during step 8, which is the step in which `state_o` has just changed. `strobe_o` is low whenever `update_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast global clock, 16 periods per slow cycle |
| rst_i | input | 1 | Synchronous reset, active high |
| next_state_i | input | DATA_W | Next-state data, sampled at step CAPT_STEP |
| phase_gray_o | output | 4 | Gray-coded sequencer state |
| phi1_o | output | 1 | First-phase enable (steps 1 to 6) |
| phi2_o | output | 1 | Second-phase enable (steps 9 to 14) |
| strobe_o | output | 1 | Registered qualifier, low in steps 7 and 8 |
| update_o | output | 1 | One-cycle pulse in the step where `state_o` was updated |
| state_o | output | DATA_W | Stable second-rank state bits |

## Verification
The bench builds the block with DATA_W = 8 and CAPT_STEP = 3. The 8-bit width makes random next-state values almost always differ between steps. A wrong rank, a capture at the wrong step or a late transfer therefore shows up as a wrong `state_o`. A capture step below the update step by an odd margin separates the two rank enables in the decode. One directed pattern drives the captured value only at step 3 and its complement at every other step. That pattern shows whether the other steps are ignored. A reset in the middle of a slow cycle covers a restart from any step.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int SEQ_W    = 4;
  localparam int NSTEPS   = 1 << SEQ_W;
  localparam int STEP_UPD = NSTEPS / 2;

  typedef logic [SEQ_W-1:0] gray_t;

  function automatic gray_t to_gray(input logic [SEQ_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [SEQ_W-1:0] from_gray(input gray_t g);
    logic [SEQ_W-1:0] b;
    b[SEQ_W-1] = g[SEQ_W-1];
    for (int i = SEQ_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/tpc_gray_seq.sv
module tpc_gray_seq
  import tpc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  output gray_t seq_q,
  output gray_t seq_nxt
);
  logic [SEQ_W-1:0] bin_cur;

  always_comb begin
    bin_cur = from_gray(seq_q);
    seq_nxt = to_gray(bin_cur + 1'b1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) seq_q <= '0;
    else       seq_q <= seq_nxt;
  end
endmodule

// File: rtl/tpc_phase_decode.sv
module tpc_phase_decode
  import tpc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  gray_t seq_nxt,
  output logic  strobe_q,
  output logic  ph1_q,
  output logic  ph2_q,
  output logic  upd_q
);
  logic strobe_d, ph1_d, ph2_d, upd_d;
  logic g3, g2, g1, g0;

  // Decode the state being entered, then register it.
  // A glitch in the decode therefore never reaches an output pin.
  always_comb begin
    {g3, g2, g1, g0} = seq_nxt;
    // Low only for x100 (steps 7 and 8). g3 is absent, so the MSB toggle
    // between those steps cannot open a gap.
    strobe_d = ~g2 | g1 | g0;
    ph1_d    = ~g3 & (g1 | g0);
    ph2_d    =  g3 & (g1 | g0);
    upd_d    =  g3 & g2 & ~g1 & ~g0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      strobe_q <= 1'b1;
      ph1_q    <= 1'b0;
      ph2_q    <= 1'b0;
      upd_q    <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      ph1_q    <= ph1_d;
      ph2_q    <= ph2_d;
      upd_q    <= upd_d;
    end
  end
endmodule

// File: rtl/tpc_two_rank.sv
module tpc_two_rank
  import tpc_pkg::*;
#(
  parameter int DATA_W    = 4,
  parameter int CAPT_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  gray_t             seq_q,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] stable_q
);
  localparam gray_t CAPT_CODE = to_gray(SEQ_W'(CAPT_STEP));
  localparam gray_t XFER_CODE = to_gray(SEQ_W'(STEP_UPD - 1));

  logic              cap_en, xfer_en;
  logic [DATA_W-1:0] master_q;

  assign cap_en  = (seq_q == CAPT_CODE);
  assign xfer_en = (seq_q == XFER_CODE);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        master_q[b] <= 1'b0;
        stable_q[b] <= 1'b0;
      end else begin
        if (cap_en)  master_q[b] <= d_i[b];
        if (xfer_en) stable_q[b] <= master_q[b];
      end
    end
  end
endmodule

// File: rtl/twophase_strobe_gen.sv
module twophase_strobe_gen
  import tpc_pkg::*;
#(
  parameter int DATA_W    = 4,
  parameter int CAPT_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] next_state_i,
  output logic [3:0]        phase_gray_o,
  output logic              phi1_o,
  output logic              phi2_o,
  output logic              strobe_o,
  output logic              update_o,
  output logic [DATA_W-1:0] state_o
);
  gray_t seq_q, seq_nxt;

  tpc_gray_seq u_seq (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .seq_q   (seq_q),
    .seq_nxt (seq_nxt)
  );

  tpc_phase_decode u_dec (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .seq_nxt  (seq_nxt),
    .strobe_q (strobe_o),
    .ph1_q    (phi1_o),
    .ph2_q    (phi2_o),
    .upd_q    (update_o)
  );

  tpc_two_rank #(.DATA_W(DATA_W), .CAPT_STEP(CAPT_STEP)) u_rank (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .seq_q    (seq_q),
    .d_i      (next_state_i),
    .stable_q (state_o)
  );

  assign phase_gray_o = seq_q;
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int DATA_W = 4
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [3:0]        phase_gray_o,
  input logic              phi1_o,
  input logic              phi2_o,
  input logic              strobe_o,
  input logic              update_o,
  input logic [DATA_W-1:0] state_o
);
  p_one_bit_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> $countones(phase_gray_o ^ $past(phase_gray_o)) == 1);

  p_phase_disjoint_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !(phi1_o && phi2_o));

  p_strobe_low_pair_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(strobe_o) |=> !strobe_o ##1 strobe_o);

  p_state_moves_on_update_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && (state_o != $past(state_o)) |-> update_o);

  p_update_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    update_o |=> !update_o);

  p_update_strobe_low_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    update_o |-> !strobe_o);
endmodule

bind twophase_strobe_gen tpc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .phase_gray_o (phase_gray_o),
  .phi1_o       (phi1_o),
  .phi2_o       (phi2_o),
  .strobe_o     (strobe_o),
  .update_o     (update_o),
  .state_o      (state_o)
);

// File: tb/twophase_strobe_gen_tb_top.sv
module twophase_strobe_gen_tb_top;
  localparam int DW  = 8;
  localparam int CAP = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [DW-1:0] nxt;
  logic [3:0]    gray;
  logic          phi1, phi2, strobe, upd;
  logic [DW-1:0] state;

  int            checks = 0;
  int            errors = 0;
  int            step;
  logic [DW-1:0] exp_master, exp_stable;
  logic [3:0]    prev_gray;
  logic          have_prev;

  always #2 clk = ~clk;

  twophase_strobe_gen #(.DATA_W(DW), .CAPT_STEP(CAP)) dut_i (
    .clk_i        (clk),
    .rst_i        (rst),
    .next_state_i (nxt),
    .phase_gray_o (gray),
    .phi1_o       (phi1),
    .phi2_o       (phi2),
    .strobe_o     (strobe),
    .update_o     (upd),
    .state_o      (state)
  );

  function automatic logic [3:0] exp_gray(input int s);
    logic [3:0] b;
    b = 4'(s);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s step=%0d actual=%0h expected=%0h", req, what, step, act, exp);
    end
  endtask

  task automatic check_step();
    chk("R2", "gray", 32'(gray), 32'(exp_gray(step)));
    if (have_prev) chk("R2", "one-bit change", 32'($countones(gray ^ prev_gray)), 32'd1);
    chk("R3", "phi1", 32'(phi1), 32'(step >= 1 && step <= 6));
    chk("R3", "phi2", 32'(phi2), 32'(step >= 9 && step <= 14));
    chk("R4", "strobe", 32'(strobe), 32'(!(step == 7 || step == 8)));
    chk("R7", "update", 32'(upd), 32'(step == 8));
    chk("R6", "state", 32'(state), 32'(exp_stable));
    prev_gray = gray;
    have_prev = 1'b1;
  endtask

  // Entered and left at a falling edge. mode 0 drives random data.
  // mode 1 drives a pattern at the capture step and its complement at
  // every other step (R5).
  task automatic run_cycles(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] d;
      check_step();
      d = DW'($urandom);
      if (mode == 1) d = (step == CAP) ? 8'hA5 : 8'h5A;
      nxt = d;
      if (step == CAP) exp_master = d;
      @(posedge clk);
      step = (step + 1) % 16;
      if (step == 8) exp_stable = exp_master;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    nxt = DW'($urandom);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R1", "gray", 32'(gray), 32'd0);
    chk("R1", "strobe", 32'(strobe), 32'd1);
    chk("R1", "phi1", 32'(phi1), 32'd0);
    chk("R1", "phi2", 32'(phi2), 32'd0);
    chk("R1", "update", 32'(upd), 32'd0);
    chk("R1", "state", 32'(state), 32'd0);
    rst        = 1'b0;
    step       = 0;
    exp_master = '0;
    exp_stable = '0;
    have_prev  = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst       = 1'b1;
    nxt       = '0;
    have_prev = 1'b0;
    step      = 0;
    @(negedge clk);
    do_reset();
    run_cycles(16 * 10, 0);
    run_cycles(16 * 4, 1);    // R5: only the capture step reaches state_o
    run_cycles(10, 0);        // stop in step 10
    do_reset();               // R1: reset in the middle of a cycle
    run_cycles(5, 0);         // stop in step 5, after the capture
    do_reset();
    run_cycles(16 * 20, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule